// File: doc/BRIEF.md
# Token-Passing Parallel Slave Port

This block is the slave side of a byte-wide, two-way parallel link between a host and a network processor. One write token decides which side drives the shared data bus. At any moment only the token holder sends. When the host holds the token, it writes a message: a length byte, that many data bytes, and an end-of-message code. When the slave holds the token, the host reads a message back in the same form. A side that has nothing to send gives a length of zero, which is the null code, and follows it with the end-of-message code. A correctly ended message always hands the token to the other side.

Each byte moves with a one-cycle host strobe. The slave answers by raising a busy flag for exactly one cycle. A single active-high interrupt line carries two kinds of event: "downlink ready", which means the length byte of a host message has been taken, and "uplink ready", which means the slave has data while the host holds the token. The host tells the two apart from the exported token-owner bit.

Top module: `tpp_slave_port`

## Requirements
- R1: After reset the host owns the token (`slave_owns`=0), and `busy`, `irq`, `err_flag`, `dbus_oe` and `dn_valid` are all 0.
- R2: While the host owns the token, the first accepted write is a length L. Each of the next L accepted writes appears on `dn_data` with a one-cycle `dn_valid` pulse in the cycle after its strobe. The next write must be the end code 0x00, and accepting it gives the token to the slave.
- R3: A length write of 0x00 (the null code) is followed directly by the end code 0x00, and that end code gives the token to the slave. No `dn_valid` pulse occurs.
- R4: Any byte other than 0x00 written where the end code is expected sets `err_flag`, returns the port to the length stage and leaves the token with the host. `err_flag` clears when the next length byte is accepted.
- R5: While the slave owns the token, `dbus_oe`=1. If `up_pend`=1 and `up_len`≠0, the first read returns `up_len`. The next `up_len` reads each return `up_byte` and pulse `up_take` once. The following read returns 0x00, and after that read the token passes to the host.
- R6: While the slave owns the token with `up_pend`=0 or `up_len`=0, the first read returns the null code 0x00 and the second read returns the end code 0x00. After the second read the token passes to the host.
- R7: An accepted strobe raises `busy` for exactly the following cycle. A strobe that arrives while `busy`=1 is ignored.
- R8: A strobe whose direction (`host_rd`=1 for a read, 0 for a write) does not match the token owner is ignored: no `busy`, no state change, no `dn_valid`. `dbus_oe` is 0 whenever the host owns the token.
- R9: After a nonzero length byte is accepted, `irq` is 1 from the cycle after `busy` falls until the next accepted strobe.
- R10: While the host owns the token, the port is in the length stage and `busy`=0, `irq` equals `up_pend`.
- R11: `irq` is 0 whenever `busy`=1, whenever the slave owns the token, and during the data and end-code stages of a downlink apart from the R9 window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_stb | input | 1 | Host byte strobe, one cycle per byte |
| host_rd | input | 1 | Strobe direction: 1 read, 0 write |
| dbus_in | input | 8 | Byte written by the host |
| dbus_out | output | 8 | Byte presented to the host when the slave owns the token |
| dbus_oe | output | 1 | Bus drive enable (slave owns the token) |
| busy | output | 1 | Byte being taken or driven; strobes are refused while high |
| irq | output | 1 | Shared interrupt request, active high |
| slave_owns | output | 1 | Token owner: 1 slave, 0 host |
| err_flag | output | 1 | Bad end code seen |
| dn_valid | output | 1 | Downlink data byte valid pulse |
| dn_data | output | 8 | Downlink data byte |
| up_pend | input | 1 | Uplink message waiting |
| up_len | input | 8 | Uplink message length |
| up_byte | input | 8 | Current uplink data byte |
| up_take | output | 1 | Uplink byte consumed |

## Verification
Downlink messages use random lengths from zero to five and random payloads. Occasionally they end with a corrupted end code. This separates the null path, the counted data path and the error recovery. Uplink turns combine a random pending flag with random lengths that include zero, so a real message can be told from a null reply, and the byte order can be told from the `up_take` count. Directed cases add a wrong-direction strobe in each token state and a strobe held through the busy cycle, which shows whether the counter moves once or twice. The interrupt is sampled during busy, in the downlink-ready window, in the data stages and in the idle state with the host holding the token, which shows which event source drives it.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_EOM  = 2'd2
    } phase_e;
endpackage

// File: rtl/tpp_link_fsm.sv
module tpp_link_fsm #(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] NULL_CODE = '0,
    parameter logic [DW-1:0] EOM_CODE  = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hs_stb,
    input  logic                host_rd,
    input  logic [DW-1:0]       din,
    input  logic                up_pend,
    input  logic [DW-1:0]       up_len,
    output logic                tok,
    output tpp_pkg::phase_e     ph,
    output logic                busy,
    output logic                dn_rdy,
    output logic                err,
    output logic                dn_valid,
    output logic [DW-1:0]       dn_data,
    output logic                up_take
);
    import tpp_pkg::*;

    typedef struct packed {
        logic          tok;
        phase_e        ph;
        logic [DW-1:0] cnt;
        logic          busy;
        logic          dn_rdy;
        logic          err;
        logic          dn_valid;
        logic [DW-1:0] dn_data;
    } st_t;

    st_t st_d, st_q;
    logic acc;
    logic last_byte;
    logic up_real;

    assign acc       = hs_stb && !st_q.busy && (host_rd == st_q.tok);
    assign last_byte = (st_q.cnt == DW'(1));
    assign up_real   = up_pend && (up_len != NULL_CODE);

    always_comb begin
        st_d          = st_q;
        st_d.busy     = acc;
        st_d.dn_valid = 1'b0;
        if (acc) begin
            st_d.dn_rdy = 1'b0;
            if (!st_q.tok) begin
                unique case (st_q.ph)
                    PH_IDLE: begin
                        st_d.err = 1'b0;
                        if (din == NULL_CODE) begin
                            st_d.ph = PH_EOM;
                        end else begin
                            st_d.ph     = PH_DATA;
                            st_d.cnt    = din;
                            st_d.dn_rdy = 1'b1;
                        end
                    end
                    PH_DATA: begin
                        st_d.dn_valid = 1'b1;
                        st_d.dn_data  = din;
                        st_d.cnt      = st_q.cnt - DW'(1);
                        if (last_byte) st_d.ph = PH_EOM;
                    end
                    PH_EOM: begin
                        st_d.ph = PH_IDLE;
                        if (din == EOM_CODE) st_d.tok = 1'b1;
                        else                 st_d.err = 1'b1;
                    end
                    default: st_d.ph = PH_IDLE;
                endcase
            end else begin
                unique case (st_q.ph)
                    PH_IDLE: begin
                        if (up_real) begin
                            st_d.ph  = PH_DATA;
                            st_d.cnt = up_len;
                        end else begin
                            st_d.ph = PH_EOM;
                        end
                    end
                    PH_DATA: begin
                        st_d.cnt = st_q.cnt - DW'(1);
                        if (last_byte) st_d.ph = PH_EOM;
                    end
                    PH_EOM: begin
                        st_d.ph  = PH_IDLE;
                        st_d.tok = 1'b0;
                    end
                    default: st_d.ph = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{tok: 1'b0, ph: PH_IDLE, cnt: '0, busy: 1'b0, dn_rdy: 1'b0,
                      err: 1'b0, dn_valid: 1'b0, dn_data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tok      = st_q.tok;
    assign ph       = st_q.ph;
    assign busy     = st_q.busy;
    assign dn_rdy   = st_q.dn_rdy;
    assign err      = st_q.err;
    assign dn_valid = st_q.dn_valid;
    assign dn_data  = st_q.dn_data;
    assign up_take  = acc && st_q.tok && (st_q.ph == PH_DATA);

    // R7
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> !st_q.busy);

    // R8
    tok_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.tok) |-> $past(hs_stb) && $past(host_rd) == $past(st_q.tok));

    // R4
    err_from_eom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> $past(st_q.ph) == PH_EOM && !st_q.tok && st_q.ph == PH_IDLE);

    // R5
    take_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_take |-> st_q.tok && hs_stb && host_rd);

    // R2
    data_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph == PH_DATA |-> st_q.cnt != '0);

    // R2
    dn_only_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dn_valid |-> !st_q.tok && st_q.busy);
endmodule

// File: rtl/tpp_bus_drive.sv
module tpp_bus_drive #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] NULL_CODE = '0,
    parameter logic [DW-1:0] EOM_CODE  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok,
    input  tpp_pkg::phase_e ph,
    input  logic            up_pend,
    input  logic [DW-1:0]   up_len,
    input  logic [DW-1:0]   up_byte,
    output logic [DW-1:0]   dout,
    output logic            oe
);
    import tpp_pkg::*;

    always_comb begin
        dout = NULL_CODE;
        if (tok) begin
            unique case (ph)
                PH_IDLE: dout = (up_pend && up_len != NULL_CODE) ? up_len : NULL_CODE;
                PH_DATA: dout = up_byte;
                PH_EOM:  dout = EOM_CODE;
                default: dout = NULL_CODE;
            endcase
        end
    end

    assign oe = tok;

    // R8
    oe_tracks_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tok |-> !oe && dout == NULL_CODE);
endmodule

// File: rtl/tpp_irq_gen.sv
module tpp_irq_gen (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok,
    input  tpp_pkg::phase_e ph,
    input  logic            busy,
    input  logic            dn_rdy,
    input  logic            up_pend,
    output logic            irq
);
    import tpp_pkg::*;

    logic up_evt;

    assign up_evt = !tok && (ph == PH_IDLE) && up_pend;
    assign irq    = !busy && (dn_rdy || up_evt);

    // R11
    irq_quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq);

    // R11
    irq_quiet_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok |-> !irq);
endmodule

// File: rtl/tpp_slave_port.sv
module tpp_slave_port #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] NULL_CODE = '0,
    parameter logic [DW-1:0] EOM_CODE  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_stb,
    input  logic          host_rd,
    input  logic [DW-1:0] dbus_in,
    output logic [DW-1:0] dbus_out,
    output logic          dbus_oe,
    output logic          busy,
    output logic          irq,
    output logic          slave_owns,
    output logic          err_flag,
    output logic          dn_valid,
    output logic [DW-1:0] dn_data,
    input  logic          up_pend,
    input  logic [DW-1:0] up_len,
    input  logic [DW-1:0] up_byte,
    output logic          up_take
);
    import tpp_pkg::*;

    logic   tok;
    phase_e ph;
    logic   dn_rdy;

    tpp_link_fsm #(.DW(DW), .NULL_CODE(NULL_CODE), .EOM_CODE(EOM_CODE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hs_stb(hs_stb), .host_rd(host_rd), .din(dbus_in),
        .up_pend(up_pend), .up_len(up_len), .tok(tok), .ph(ph), .busy(busy),
        .dn_rdy(dn_rdy), .err(err_flag), .dn_valid(dn_valid), .dn_data(dn_data),
        .up_take(up_take)
    );

    tpp_bus_drive #(.DW(DW), .NULL_CODE(NULL_CODE), .EOM_CODE(EOM_CODE)) u_bus (
        .clk(clk), .rst_n(rst_n), .tok(tok), .ph(ph), .up_pend(up_pend),
        .up_len(up_len), .up_byte(up_byte), .dout(dbus_out), .oe(dbus_oe)
    );

    tpp_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .tok(tok), .ph(ph), .busy(busy),
        .dn_rdy(dn_rdy), .up_pend(up_pend), .irq(irq)
    );

    assign slave_owns = tok;

    // R9
    irq_drops_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && hs_stb && host_rd == slave_owns |=> !irq);
endmodule

// File: tb/sim_tpp_slave_port.sv
module sim_tpp_slave_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_stb = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] dbus_in = '0;
    logic [7:0] dbus_out;
    logic       dbus_oe, busy, irq, slave_owns, err_flag, dn_valid, up_take;
    logic [7:0] dn_data;
    logic       up_pend = 1'b0;
    logic [7:0] up_len = '0;
    logic [7:0] up_byte;
    logic [7:0] up_mem [0:7];
    int         up_idx = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign up_byte = up_mem[up_idx[2:0]];
    always @(posedge clk) if (up_take) up_idx <= up_idx + 1;

    tpp_slave_port u0 (
        .clk(clk), .rst_n(rst_n), .hs_stb(hs_stb), .host_rd(host_rd), .dbus_in(dbus_in),
        .dbus_out(dbus_out), .dbus_oe(dbus_oe), .busy(busy), .irq(irq),
        .slave_owns(slave_owns), .err_flag(err_flag), .dn_valid(dn_valid),
        .dn_data(dn_data), .up_pend(up_pend), .up_len(up_len), .up_byte(up_byte),
        .up_take(up_take)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_up_irq(input logic owns, input logic pend);
        return !owns && pend;
    endfunction

    function automatic logic [7:0] exp_first(input logic pend, input logic [7:0] len);
        return (pend && len != 8'h00) ? len : 8'h00;
    endfunction

    // One strobe; returns at the negedge after the sampling edge.
    task automatic strobe(input logic rd, input logic [7:0] b, output logic [7:0] got);
        @(negedge clk);
        hs_stb = 1'b1; host_rd = rd; dbus_in = b;
        #1 got = dbus_out;
        @(negedge clk);
        hs_stb = 1'b0;
    endtask

    task automatic down_msg(input int len, input logic [7:0] eom);
        logic [7:0] g, d;
        strobe(1'b0, 8'(len), g);
        chk("R7 busy after length", busy, 1'b1);
        chk("R11 irq low while busy", irq, 1'b0);
        @(negedge clk);
        chk("R4 err cleared by length", err_flag, 1'b0);
        if (len != 0) chk("R9 downlink ready irq", irq, 1'b1);
        else          chk("R3 null gives no irq", irq, 1'b0);
        for (int i = 0; i < len; i++) begin
            d = 8'($urandom);
            strobe(1'b0, d, g);
            chk("R2 dn_valid pulse", dn_valid, 1'b1);
            chk("R2 dn_data", dn_data, d);
            @(negedge clk);
            chk("R2 dn_valid one cycle", dn_valid, 1'b0);
            chk("R11 irq low in downlink", irq, 1'b0);
        end
        strobe(1'b0, eom, g);
        chk("R2 no data on end code", dn_valid, 1'b0);
        @(negedge clk);
        if (eom == 8'h00) begin
            chk(len != 0 ? "R2 token to slave" : "R3 token to slave", slave_owns, 1'b1);
            chk("R11 irq low slave owner", irq, 1'b0);
        end else begin
            chk("R4 err set", err_flag, 1'b1);
            chk("R4 token kept by host", slave_owns, 1'b0);
            chk("R10 irq idle", irq, exp_up_irq(1'b0, up_pend));
        end
    endtask

    task automatic up_msg(input logic pend, input int len);
        logic [7:0] g, e;
        for (int i = 0; i < 8; i++) up_mem[i] = 8'($urandom);
        @(negedge clk);
        up_pend = pend; up_len = 8'(len); up_idx = 0;
        #1;
        chk("R5 bus driven", dbus_oe, 1'b1);
        chk("R11 irq low slave owner", irq, 1'b0);
        e = exp_first(pend, 8'(len));
        strobe(1'b1, 8'hA5, g);
        chk(e != 0 ? "R5 length read" : "R6 null read", g, e);
        @(negedge clk);
        if (e != 0) begin
            for (int i = 0; i < len; i++) begin
                strobe(1'b1, 8'h00, g);
                chk("R5 data read", g, up_mem[i]);
                @(negedge clk);
            end
            chk("R5 up_take count", up_idx, len);
        end
        strobe(1'b1, 8'h00, g);
        chk(e != 0 ? "R5 end code read" : "R6 end code read", g, 8'h00);
        @(negedge clk);
        chk(e != 0 ? "R5 token to host" : "R6 token to host", slave_owns, 1'b0);
        chk("R8 bus released", dbus_oe, 1'b0);
        chk("R10 uplink irq", irq, exp_up_irq(1'b0, pend));
        up_pend = 1'b0;
        #1 chk("R10 irq follows pend", irq, 1'b0);
    endtask

    initial begin
        logic [7:0] g;
        for (int i = 0; i < 8; i++) up_mem[i] = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 token to host", slave_owns, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 err", err_flag, 1'b0);
        chk("R1 oe", dbus_oe, 1'b0);
        chk("R1 dn_valid", dn_valid, 1'b0);

        // R8 read while host owns: ignored
        strobe(1'b1, 8'h00, g);
        chk("R8 read ignored busy", busy, 1'b0);
        chk("R8 oe off", dbus_oe, 1'b0);

        // R10 uplink request with host holding token
        up_pend = 1'b1; #1;
        chk("R10 irq on pend", irq, 1'b1);
        up_pend = 1'b0; #1;
        chk("R10 irq off", irq, 1'b0);

        // R7 strobe held through busy: counter moves once
        strobe(1'b0, 8'd2, g);
        @(negedge clk);
        hs_stb = 1'b1; host_rd = 1'b0; dbus_in = 8'h3C;
        @(negedge clk);
        chk("R7 busy", busy, 1'b1);
        chk("R2 first data", dn_data, 8'h3C);
        @(negedge clk);
        hs_stb = 1'b0;
        chk("R7 held strobe ignored", busy, 1'b0);
        chk("R7 no second pulse", dn_valid, 1'b0);
        strobe(1'b0, 8'h5A, g);
        chk("R7 second data still data", dn_valid, 1'b1);
        @(negedge clk);
        strobe(1'b0, 8'h00, g);
        @(negedge clk);
        chk("R2 token after held case", slave_owns, 1'b1);

        // R8 write while slave owns: ignored
        strobe(1'b0, 8'h77, g);
        chk("R8 write ignored busy", busy, 1'b0);
        chk("R8 write ignored data", dn_valid, 1'b0);
        chk("R8 token unchanged", slave_owns, 1'b1);

        up_msg(1'b0, 3);
        down_msg(0, 8'h00);
        up_msg(1'b1, 0);
        down_msg(1, 8'h09);
        down_msg(3, 8'h00);
        up_msg(1'b1, 4);

        for (int it = 0; it < 25; it++) begin
            down_msg(int'($urandom % 6), ($urandom % 8 == 0) ? 8'h11 : 8'h00);
            if (slave_owns) up_msg(1'($urandom % 2), int'($urandom % 5));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule